// File: doc/BRIEF.md
# Set-Associative Tag Directory with Line Permissions

This block is the tag side of a set-associative cache. Every way of every set holds a line address, a five-state access permission and a lock-owner context. A single command port accepts one operation per cycle. The operations are access checks, presence tests, space queries, victim probes, allocation, release, recency updates, permission writes and lock operations. Each command produces a registered response in the following cycle.

Replacement is true LRU, kept per set as a rank for each way. An access check updates the rank when its tag matches, and so does an explicit recency command. Allocation updates the rank only in its touching variant. Data storage, the coherence protocol and statistics sit outside the block. The controller drives permissions through the permission-write command.

The set index is taken from the line address starting at bit `IDX_LSB`. It is `log2(NUM_SETS)` bits wide, where `NUM_SETS = CACHE_BYTES / WAYS / LINE_BYTES` and must exceed 1.

Top module: `tag_directory`

## Requirements
- R1: The set is `cmd_addr_i[IDX_LSB +: log2(NUM_SETS)]`. Addresses that differ only outside those bits compete for the ways of one set. Addresses with a different index never see each other's lines.
- R2: Permission codes are 0 absent-marked, 1 invalid, 2 read-only, 3 read-write and 4 busy. A line is found only when its way is occupied, its address equals the request and its permission is not 0. Presence (op 2) reports found and the found way.
- R3: Access check (op 1) succeeds on a found line with permission 3 for any request type. With permission 2 it succeeds only for request type 0 (load) or 2 (fetch). It fails for type 1 (store) and every other case.
- R4: Rank is true LRU per set. After reset, way 0 is least recent, then way 1, and so on. A found access check (op 1) or a found recency command (op 8) makes that way most recent. The touching allocate (op 6) does the same for the way it writes.
- R5: The space query (op 3) is true when the address is found in its set, or when any way of the set is empty or holds permission 0.
- R6: Allocate (ops 5 and 6) writes the way that holds the same address with permission 0 if there is one. Otherwise it writes the lowest-numbered empty or permission-0 way. The written way gets permission 1 and lock context all ones, and the response returns that way.
- R7: Release (op 7) of a found line empties its way. Release of an absent line changes nothing and answers not-ok.
- R8: Probe (op 4) on a set with no space answers ok with the least recent way and its stored address. When the set has space, it answers not-ok with way 0 and address 0.
- R9: Lock set (op 9) stores `cmd_ctx_i` on a found line, and lock clear (op 10) stores all ones. Lock test (op 11) is true only when the stored context equals `cmd_ctx_i`.
- R10: Allocating a found address, allocating into a full set, or any lock op on an absent line sets `err_o`, which stays set until reset. Such a command leaves all lines unchanged.
- R11: Permission write (op 12) stores `cmd_perm_i` on an occupied way whose address matches, whatever its current permission.
- R12: `resp_valid_o` is high exactly in the cycle after a command is accepted. Reset empties every way and clears `err_o` and the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 4 | Opcode (1..12, others no-op) |
| cmd_addr_i | input | ADDR_W | Line address |
| cmd_req_i | input | 2 | Request type for access checks |
| cmd_ctx_i | input | CTX_W | Lock context |
| cmd_perm_i | input | 3 | Permission for op 12 |
| resp_valid_o | output | 1 | Response strobe |
| resp_ok_o | output | 1 | Result of the command |
| resp_way_o | output | WAY_W | Found, written or victim way |
| resp_addr_o | output | ADDR_W | Victim address on a probe |
| err_o | output | 1 | Sticky illegal-command flag |

## Verification
The bench uses the defaults: a 1 KiB cache, 64-byte lines and 4 ways. That gives 4 sets, with the index at bits 7:6 of a 20-bit address. Random addresses are drawn from six tags in each of four sets, so sets fill often. This brings full-set allocation errors, victim probes, reuse of absent-marked ways and LRU reordering into reach within a few thousand commands. Directed steps first cover the reset rank order, the read-only store rule and the unlocked context value before the error flag is set.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;
  typedef enum logic [3:0] {
    OP_NOP         = 4'd0,
    OP_ACCESS      = 4'd1,
    OP_PRESENT     = 4'd2,
    OP_AVAIL       = 4'd3,
    OP_PROBE       = 4'd4,
    OP_ALLOC       = 4'd5,
    OP_ALLOC_TOUCH = 4'd6,
    OP_DEALLOC     = 4'd7,
    OP_SET_MRU     = 4'd8,
    OP_LOCK_SET    = 4'd9,
    OP_LOCK_CLR    = 4'd10,
    OP_LOCK_TEST   = 4'd11,
    OP_SET_PERM    = 4'd12
  } op_e;

  typedef enum logic [2:0] {
    PERM_ABSENT = 3'd0,
    PERM_INVAL  = 3'd1,
    PERM_RO     = 3'd2,
    PERM_RW     = 3'd3,
    PERM_BUSY   = 3'd4
  } perm_e;

  localparam logic [1:0] REQ_LOAD  = 2'd0;
  localparam logic [1:0] REQ_STORE = 2'd1;
  localparam logic [1:0] REQ_FETCH = 2'd2;
endpackage

// File: rtl/tagdir_lookup.sv
module tagdir_lookup #(
  parameter int WAYS   = 4,
  parameter int ADDR_W = 20,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]             vld_i,
  input  logic [WAYS-1:0][ADDR_W-1:0] addr_i,
  input  logic [WAYS-1:0][2:0]        perm_i,
  input  logic [ADDR_W-1:0]           req_addr_i,
  output logic [WAYS-1:0]             hit_vec_o,
  output logic                        hit_o,
  output logic [WAY_W-1:0]            hit_way_o,
  output logic                        tag_o,
  output logic [WAY_W-1:0]            tag_way_o,
  output logic                        free_o,
  output logic [WAY_W-1:0]            free_way_o
);
  import tagdir_pkg::*;

  logic [WAYS-1:0] tag_vec, free_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign tag_vec[w]   = vld_i[w] && (addr_i[w] == req_addr_i);
    assign hit_vec_o[w] = tag_vec[w] && (perm_i[w] != PERM_ABSENT);
    assign free_vec[w]  = !vld_i[w] || (perm_i[w] == PERM_ABSENT);
  end

  assign hit_o  = |hit_vec_o;
  assign tag_o  = |tag_vec;
  assign free_o = |free_vec;

  // lowest index wins
  always_comb begin
    hit_way_o  = '0;
    tag_way_o  = '0;
    free_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec_o[w]) hit_way_o  = WAY_W'(w);
      if (tag_vec[w])   tag_way_o  = WAY_W'(w);
      if (free_vec[w])  free_way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/tagdir_lru.sv
module tagdir_lru #(
  parameter int NUM_SETS = 4,
  parameter int WAYS     = 4,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [SET_W-1:0] touch_set_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic [SET_W-1:0] rd_set_i,
  output logic [WAY_W-1:0] victim_way_o
);
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  // rank 0 = most recent, WAYS-1 = victim
  logic [NUM_SETS-1:0][WAYS-1:0][WAY_W-1:0] rank_q;
  logic [WAYS-1:0] vic_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < WAYS; w++)
          rank_q[s][w] <= WAY_W'(WAYS - 1 - w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i)
          rank_q[touch_set_i][w] <= '0;
        else if (rank_q[touch_set_i][w] < rank_q[touch_set_i][touch_way_i])
          rank_q[touch_set_i][w] <= rank_q[touch_set_i][w] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      vic_mask[w] = (rank_q[rd_set_i][w] == OLDEST);
      if (vic_mask[w]) victim_way_o = WAY_W'(w);
    end
  end

  logic             chk_touch_q;
  logic [SET_W-1:0] chk_set_q;
  logic [WAY_W-1:0] chk_way_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_touch_q <= 1'b0;
      chk_set_q   <= '0;
      chk_way_q   <= '0;
    end else begin
      chk_touch_q <= touch_i;
      chk_set_q   <= touch_set_i;
      chk_way_q   <= touch_way_i;
    end
  end

  AST_ONE_VICTIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(vic_mask) == 1); // R4
  AST_TOUCH_MRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_touch_q |-> rank_q[chk_set_q][chk_way_q] == '0); // R4
endmodule

// File: rtl/tag_directory.sv
module tag_directory #(
  parameter int ADDR_W      = 20,
  parameter int CACHE_BYTES = 1024,
  parameter int LINE_BYTES  = 64,
  parameter int WAYS        = 4,
  parameter int IDX_LSB     = 6,
  parameter int CTX_W       = 8,
  localparam int NUM_SETS   = CACHE_BYTES / WAYS / LINE_BYTES,
  localparam int SET_W      = $clog2(NUM_SETS),
  localparam int WAY_W      = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [3:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [1:0]        cmd_req_i,
  input  logic [CTX_W-1:0]  cmd_ctx_i,
  input  logic [2:0]        cmd_perm_i,
  output logic              resp_valid_o,
  output logic              resp_ok_o,
  output logic [WAY_W-1:0]  resp_way_o,
  output logic [ADDR_W-1:0] resp_addr_o,
  output logic              err_o
);
  import tagdir_pkg::*;

  localparam logic [CTX_W-1:0] UNLOCKED = '1;

  logic [NUM_SETS-1:0][WAYS-1:0]             vld_q;
  logic [NUM_SETS-1:0][WAYS-1:0][ADDR_W-1:0] addr_q;
  logic [NUM_SETS-1:0][WAYS-1:0][2:0]        perm_q;
  logic [NUM_SETS-1:0][WAYS-1:0][CTX_W-1:0]  lock_q;

  logic [SET_W-1:0] set_idx;
  assign set_idx = cmd_addr_i[IDX_LSB +: SET_W];

  logic [WAYS-1:0]             s_vld;
  logic [WAYS-1:0][ADDR_W-1:0] s_addr;
  logic [WAYS-1:0][2:0]        s_perm;
  logic [WAYS-1:0][CTX_W-1:0]  s_lock;
  assign s_vld  = vld_q[set_idx];
  assign s_addr = addr_q[set_idx];
  assign s_perm = perm_q[set_idx];
  assign s_lock = lock_q[set_idx];

  logic [WAYS-1:0]  hit_vec;
  logic             hit, tag_hit, any_free;
  logic [WAY_W-1:0] hit_way, tag_way, free_way, victim_way;

  tagdir_lookup #(.WAYS(WAYS), .ADDR_W(ADDR_W)) i_lookup (
    .vld_i      (s_vld),
    .addr_i     (s_addr),
    .perm_i     (s_perm),
    .req_addr_i (cmd_addr_i),
    .hit_vec_o  (hit_vec),
    .hit_o      (hit),
    .hit_way_o  (hit_way),
    .tag_o      (tag_hit),
    .tag_way_o  (tag_way),
    .free_o     (any_free),
    .free_way_o (free_way)
  );

  logic             touch;
  logic [WAY_W-1:0] touch_way;

  tagdir_lru #(.NUM_SETS(NUM_SETS), .WAYS(WAYS)) i_lru (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .touch_i      (touch),
    .touch_set_i  (set_idx),
    .touch_way_i  (touch_way),
    .rd_set_i     (set_idx),
    .victim_way_o (victim_way)
  );

  logic              nxt_ok, set_err;
  logic [WAY_W-1:0]  nxt_way, wr_way;
  logic [ADDR_W-1:0] nxt_addr;
  logic              wr_alloc, wr_dealloc, wr_lock, wr_perm;
  logic [CTX_W-1:0]  lock_val;
  logic [2:0]        hit_perm;
  op_e               op;

  assign op       = op_e'(cmd_op_i);
  assign hit_perm = s_perm[hit_way];

  always_comb begin
    nxt_ok     = 1'b0;
    nxt_way    = '0;
    nxt_addr   = '0;
    set_err    = 1'b0;
    touch      = 1'b0;
    touch_way  = hit_way;
    wr_alloc   = 1'b0;
    wr_dealloc = 1'b0;
    wr_lock    = 1'b0;
    wr_perm    = 1'b0;
    wr_way     = hit_way;
    lock_val   = cmd_ctx_i;
    if (cmd_valid_i) begin
      case (op)
        OP_ACCESS: if (hit) begin
          touch   = 1'b1;
          nxt_way = hit_way;
          nxt_ok  = (hit_perm == PERM_RW) ||
                    ((hit_perm == PERM_RO) &&
                     ((cmd_req_i == REQ_LOAD) || (cmd_req_i == REQ_FETCH)));
        end
        OP_PRESENT: begin
          nxt_ok  = hit;
          nxt_way = hit ? hit_way : '0;
        end
        OP_AVAIL: nxt_ok = hit || any_free;
        OP_PROBE: if (!hit && !any_free) begin
          nxt_ok   = 1'b1;
          nxt_way  = victim_way;
          nxt_addr = s_addr[victim_way];
        end
        OP_ALLOC, OP_ALLOC_TOUCH: begin
          if (hit || !any_free) begin
            set_err = 1'b1;
          end else begin
            // reuse a matching absent-marked way to keep tags unique
            wr_way    = tag_hit ? tag_way : free_way;
            wr_alloc  = 1'b1;
            nxt_ok    = 1'b1;
            nxt_way   = wr_way;
            touch     = (op == OP_ALLOC_TOUCH);
            touch_way = wr_way;
          end
        end
        OP_DEALLOC: if (hit) begin
          wr_dealloc = 1'b1;
          nxt_ok     = 1'b1;
          nxt_way    = hit_way;
        end
        OP_SET_MRU: if (hit) begin
          touch   = 1'b1;
          nxt_ok  = 1'b1;
          nxt_way = hit_way;
        end
        OP_LOCK_SET, OP_LOCK_CLR: begin
          if (hit) begin
            wr_lock  = 1'b1;
            lock_val = (op == OP_LOCK_CLR) ? UNLOCKED : cmd_ctx_i;
            nxt_ok   = 1'b1;
            nxt_way  = hit_way;
          end else begin
            set_err = 1'b1;
          end
        end
        OP_LOCK_TEST: begin
          if (hit) begin
            nxt_ok  = (s_lock[hit_way] == cmd_ctx_i);
            nxt_way = hit_way;
          end else begin
            set_err = 1'b1;
          end
        end
        OP_SET_PERM: if (tag_hit) begin
          wr_perm = 1'b1;
          wr_way  = tag_way;
          nxt_ok  = 1'b1;
          nxt_way = tag_way;
        end
        default: ;
      endcase
    end
  end

  logic              resp_valid_q, resp_ok_q, err_q;
  logic [WAY_W-1:0]  resp_way_q;
  logic [ADDR_W-1:0] resp_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q        <= '0;
      addr_q       <= '0;
      perm_q       <= '0;
      lock_q       <= '1;
      resp_valid_q <= 1'b0;
      resp_ok_q    <= 1'b0;
      resp_way_q   <= '0;
      resp_addr_q  <= '0;
      err_q        <= 1'b0;
    end else begin
      resp_valid_q <= cmd_valid_i;
      resp_ok_q    <= nxt_ok;
      resp_way_q   <= nxt_way;
      resp_addr_q  <= nxt_addr;
      if (set_err) err_q <= 1'b1;
      if (wr_alloc) begin
        vld_q[set_idx][wr_way]  <= 1'b1;
        addr_q[set_idx][wr_way] <= cmd_addr_i;
        perm_q[set_idx][wr_way] <= PERM_INVAL;
        lock_q[set_idx][wr_way] <= UNLOCKED;
      end
      if (wr_dealloc) begin
        vld_q[set_idx][wr_way]  <= 1'b0;
        perm_q[set_idx][wr_way] <= PERM_ABSENT;
      end
      if (wr_lock) lock_q[set_idx][wr_way] <= lock_val;
      if (wr_perm) perm_q[set_idx][wr_way] <= cmd_perm_i;
    end
  end

  assign resp_valid_o = resp_valid_q;
  assign resp_ok_o    = resp_ok_q;
  assign resp_way_o   = resp_way_q;
  assign resp_addr_o  = resp_addr_q;
  assign err_o        = err_q;

  logic             chk_alloc_q;
  logic [SET_W-1:0] chk_set_q;
  logic [WAY_W-1:0] chk_way_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_alloc_q <= 1'b0;
      chk_set_q   <= '0;
      chk_way_q   <= '0;
    end else begin
      chk_alloc_q <= wr_alloc;
      chk_set_q   <= set_idx;
      chk_way_q   <= wr_way;
    end
  end

  AST_UNIQUE_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec)); // R2
  AST_ALLOC_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_alloc_q |-> (perm_q[chk_set_q][chk_way_q] == PERM_INVAL) &&
                    (lock_q[chk_set_q][chk_way_q] == UNLOCKED) &&
                    vld_q[chk_set_q][chk_way_q] && resp_ok_o); // R6
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R10
  AST_ERR_KEEPS_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_err |=> $stable(vld_q) && $stable(perm_q) && $stable(lock_q)); // R10
  AST_PROBE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && op == OP_PROBE && any_free) |=> !resp_ok_o); // R8
endmodule

// File: tb/test_tag_directory.sv
`timescale 1ns/1ps
module test_tag_directory;
  localparam int NS = 4;
  localparam int NW = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [3:0]  cmd_op_i = '0;
  logic [19:0] cmd_addr_i = '0;
  logic [1:0]  cmd_req_i = '0;
  logic [7:0]  cmd_ctx_i = '0;
  logic [2:0]  cmd_perm_i = '0;
  logic        resp_valid_o, resp_ok_o, err_o;
  logic [1:0]  resp_way_o;
  logic [19:0] resp_addr_o;

  always #2 clk_i = ~clk_i;

  tag_directory #(.ADDR_W(20), .CACHE_BYTES(1024), .LINE_BYTES(64), .WAYS(4),
                  .IDX_LSB(6), .CTX_W(8)) i_tag_directory (.*);

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int m_vld[NS][NW];
  int m_addr[NS][NW];
  int m_perm[NS][NW];
  int m_lock[NS][NW];
  int m_rank[NS][NW];
  int m_err;

  function automatic void m_touch(int s, int w);
    for (int i = 0; i < NW; i++)
      if (i != w && m_rank[s][i] < m_rank[s][w]) m_rank[s][i]++;
    m_rank[s][w] = 0;
  endfunction

  function automatic int m_victim(int s);
    int v = 0;
    for (int i = 0; i < NW; i++) if (m_rank[s][i] == NW - 1) v = i;
    return v;
  endfunction

  function automatic string tag_of(int op);
    case (op)
      1: return "R3";
      2: return "R2";
      3: return "R5";
      4: return "R8";
      5, 6: return "R6";
      7: return "R7";
      8: return "R4";
      9, 10, 11: return "R9";
      12: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic run(int op, int addr, int req, int ctx, int perm, string tag);
    int s = (addr >> 6) & 3;
    int hit = -1, tg = -1, fr = -1, w;
    int eok = 0, eway = 0, eaddr = 0;
    for (int i = NW - 1; i >= 0; i--) begin
      if (m_vld[s][i] && m_addr[s][i] == addr) begin
        tg = i;
        if (m_perm[s][i] != 0) hit = i;
      end
      if (!m_vld[s][i] || m_perm[s][i] == 0) fr = i;
    end
    case (op)
      1: if (hit >= 0) begin
        eway = hit;
        eok = (m_perm[s][hit] == 3) || (m_perm[s][hit] == 2 && (req == 0 || req == 2));
        m_touch(s, hit);
      end
      2: begin eok = hit >= 0; eway = (hit >= 0) ? hit : 0; end
      3: eok = (hit >= 0) || (fr >= 0);
      4: if (hit < 0 && fr < 0) begin
        eok = 1; eway = m_victim(s); eaddr = m_addr[s][eway];
      end
      5, 6: if (hit >= 0 || fr < 0) m_err = 1;
      else begin
        w = (tg >= 0) ? tg : fr;
        m_vld[s][w] = 1; m_addr[s][w] = addr; m_perm[s][w] = 1; m_lock[s][w] = 255;
        eok = 1; eway = w;
        if (op == 6) m_touch(s, w);
      end
      7: if (hit >= 0) begin
        m_vld[s][hit] = 0; m_perm[s][hit] = 0; eok = 1; eway = hit;
      end
      8: if (hit >= 0) begin m_touch(s, hit); eok = 1; eway = hit; end
      9, 10: if (hit >= 0) begin
        m_lock[s][hit] = (op == 10) ? 255 : ctx; eok = 1; eway = hit;
      end else m_err = 1;
      11: if (hit >= 0) begin eok = (m_lock[s][hit] == ctx); eway = hit; end
      else m_err = 1;
      12: if (tg >= 0) begin m_perm[s][tg] = perm; eok = 1; eway = tg; end
      default: ;
    endcase
    cmd_valid_i = 1'b1;
    cmd_op_i = 4'(op);
    cmd_addr_i = 20'(addr);
    cmd_req_i = 2'(req);
    cmd_ctx_i = 8'(ctx);
    cmd_perm_i = 3'(perm);
    @(negedge clk_i);
    checks++;
    if (resp_valid_o !== 1'b1 || resp_ok_o !== 1'(eok) || int'(resp_way_o) != eway ||
        int'(resp_addr_o) != eaddr || err_o !== 1'(m_err)) begin
      fails++;
      $display("FAIL %s op=%0d addr=%h actual v/ok/way/addr/err=%0d/%0d/%0d/%h/%0d expected=1/%0d/%0d/%h/%0d",
               tag, op, addr, resp_valid_o, resp_ok_o, resp_way_o, resp_addr_o, err_o,
               eok, eway, eaddr, m_err);
    end
  endtask

  function automatic int la(int t, int s);
    return (t << 8) | (s << 6);
  endfunction

  initial begin
    #600000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        m_vld[s][w] = 0; m_addr[s][w] = 0; m_perm[s][w] = 0;
        m_lock[s][w] = 255; m_rank[s][w] = NW - 1 - w;
      end
    m_err = 0;
    repeat (3) @(negedge clk_i);
    check("R12", "reset resp_valid", int'(resp_valid_o), 0);
    check("R12", "reset err", int'(err_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    run(2, la(1, 0), 0, 0, 0, "R2");
    run(3, la(1, 0), 0, 0, 0, "R5");
    run(4, la(1, 0), 0, 0, 0, "R8");
    for (int t = 1; t <= 4; t++) run(5, la(t, 0), 0, 0, 0, "R6");
    run(2, la(1, 1), 0, 0, 0, "R1");
    run(1, la(1, 0), 0, 0, 0, "R3");
    run(4, la(5, 0), 0, 0, 0, "R4");
    run(3, la(5, 0), 0, 0, 0, "R1");
    run(12, la(2, 0), 0, 0, 2, "R11");
    run(1, la(2, 0), 1, 0, 0, "R3");
    run(1, la(2, 0), 0, 0, 0, "R3");
    run(1, la(2, 0), 2, 0, 0, "R3");
    run(12, la(3, 0), 0, 0, 3, "R11");
    run(1, la(3, 0), 1, 0, 0, "R3");
    run(11, la(1, 0), 0, 255, 0, "R9");
    run(9, la(1, 0), 0, 5, 0, "R9");
    run(11, la(1, 0), 0, 5, 0, "R9");
    run(11, la(1, 0), 0, 6, 0, "R9");
    run(10, la(1, 0), 0, 0, 0, "R9");
    run(11, la(1, 0), 0, 5, 0, "R9");
    run(8, la(4, 0), 0, 0, 0, "R4");
    run(4, la(6, 0), 0, 0, 0, "R4");
    run(7, la(2, 0), 0, 0, 0, "R7");
    run(2, la(2, 0), 0, 0, 0, "R7");
    run(7, la(2, 0), 0, 0, 0, "R7");
    run(6, la(6, 0), 0, 0, 0, "R6");
    run(12, la(3, 0), 0, 0, 0, "R11");
    run(2, la(3, 0), 0, 0, 0, "R2");
    run(3, la(7, 0), 0, 0, 0, "R5");
    run(5, la(3, 0), 0, 0, 0, "R6");
    run(5, la(7, 0), 0, 0, 0, "R10");
    run(2, la(7, 0), 0, 0, 0, "R10");
    run(5, la(1, 0), 0, 0, 0, "R10");
    run(9, la(9, 2), 0, 3, 0, "R10");

    for (int n = 0; n < 4000; n++) begin
      int op = 1 + int'($urandom % 12);
      int a = la(int'($urandom % 6), int'($urandom % 4));
      if ($urandom % 3 == 0) op = 5 + int'($urandom % 2);
      run(op, a, int'($urandom % 4), int'($urandom % 4), int'($urandom % 5), tag_of(op));
    end

    cmd_valid_i = 1'b0;
    cmd_op_i = '0;
    @(negedge clk_i);
    check("R12", "idle resp_valid", int'(resp_valid_o), 0);
    check("R10", "sticky err", int'(err_o), 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule